// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the bit-level master for an open-drain single-wire bus that idles high through a pull-up resistor. A controller hands it one command at a time: a bus reset with presence detection, a one-bit write, a one-bit read, or a timed strong-pullup phase. The engine pulls the wire low through an active-low drive enable, releases it at fixed points and samples the wire at fixed points. It then reports completion with a single result bit. That bit is the presence flag after a reset and the received bit after a read.

All timing is counted in microseconds. A prescaler divides the system clock by `CLK_PER_US` to produce the microsecond tick. Every window is a parameter in microseconds. The strong-pullup command powers slaves that draw their supply from the wire during long internal operations. It asserts its enable on the cycle after acceptance, keeps the wire released, and holds for one of two programmable durations. Byte framing, command protocols and the analog drive are handled outside this block.

Top module: `owm_slot_engine`

## Requirements
- R1: After reset the engine is idle: `cmd_ready`=1, `line_pull_n`=1 (wire released), `spu_en`=0 and `result_valid`=0.
- R2: A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 for exactly the command's duration × `CLK_PER_US` cycles. Completion is marked by a one-cycle `result_valid` pulse, with `cmd_ready` back at 1 in that cycle.
- R3: The `cmd_op` encoding is: 2'b00 bus reset, 2'b01 write bit (`cmd_bit` is the value), 2'b10 read bit, 2'b11 strong pullup (`cmd_bit`=1 selects the long duration, 0 the short one).
- R4: A bus reset drives the wire low for exactly `RST_LOW_US` µs from acceptance. It then releases the wire and listens for `RST_REL_US` µs, so the total is `RST_LOW_US`+`RST_REL_US` µs.
- R5: During a bus reset the wire is sampled `PRES_SAMPLE_US` µs after release. `result_bit` is 1 when the wire was low at that point (presence) and 0 when it was high.
- R6: A write-0 drives the wire low for `W0_LOW_US` µs. A write-1 drives it low for `W1_LOW_US` µs. Both slots last `SLOT_US` µs, so a slave sampling 30 µs after the falling edge reads the written value. `result_bit` is 0 after a write.
- R7: A read slot drives the wire low for `RD_LOW_US` µs and lasts `SLOT_US` µs. `result_bit` equals the wire level sampled `RD_SAMPLE_US` µs after the falling edge.
- R8: The wire is driven low only while a command is in progress. It is never driven low for more than `RST_LOW_US` µs in a row, and it is released for the final microseconds of every slot.
- R9: The strong-pullup command asserts `spu_en` from the cycle after acceptance for exactly `SPU_LONG_US` or `SPU_SHORT_US` µs. The wire stays released throughout, and `result_bit` is 0.
- R10: A `cmd_valid` presented while a command is in progress has no effect: the running command keeps its duration, and the ignored request starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, can accept a command |
| cmd_op | input | 2 | Command code (see R3) |
| cmd_bit | input | 1 | Write value, or long/short pullup select |
| line_in | input | 1 | Sampled wire level |
| line_pull_n | output | 1 | Active-low drive enable; 0 pulls the wire low |
| spu_en | output | 1 | Strong-pullup enable |
| result_valid | output | 1 | One-cycle completion pulse |
| result_bit | output | 1 | Presence flag or read bit |

## Verification
Every duration is due an exact whole number of cycles after the acceptance edge: the command length in µs times `CLK_PER_US`. The low phase and the pullup phase begin on the first cycle after that edge. The bench therefore counts, on falling clock edges from acceptance until `result_valid` is seen, how many cycles the wire was driven, the engine was busy and the pullup was on. It compares these counts with the µs parameters multiplied out. A behavioural slave on the wired-AND line answers resets with presence, drives read zeros and samples written bits at 30 µs. Results are checked at the falling edge on which `result_valid` is first high.

// File: rtl/owm_slot_engine.sv
module owm_slot_engine #(
  parameter int CLK_PER_US     = 200,
  parameter int RST_LOW_US     = 480,
  parameter int RST_REL_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int SLOT_US        = 70,
  parameter int W0_LOW_US      = 60,
  parameter int W1_LOW_US      = 6,
  parameter int RD_LOW_US      = 2,
  parameter int RD_SAMPLE_US   = 13,
  parameter int SPU_SHORT_US   = 10000,
  parameter int SPU_LONG_US    = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       line_in,
  output logic       line_pull_n,
  output logic       spu_en,
  output logic       result_valid,
  output logic       result_bit
);
  localparam int RST_END = RST_LOW_US + RST_REL_US;
  localparam int MAX_US  = (SPU_LONG_US > RST_END) ? SPU_LONG_US : RST_END;
  localparam int UW      = $clog2(MAX_US + 1);
  localparam int PW      = $clog2(CLK_PER_US + 1);

  localparam logic [1:0] OP_RST = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_SPU = 2'b11;

  logic          busy, dbit;
  logic [1:0]    op;
  logic [PW-1:0] pre;
  logic [UW-1:0] us;
  logic [1:0]    line_s;
  logic [UW-1:0] low_us, end_us, samp_us;
  logic          has_samp;

  wire tick = (pre == PW'(CLK_PER_US - 1));

  always_comb begin
    has_samp = 1'b0;
    samp_us  = '0;
    case (op)
      OP_RST: begin
        low_us = UW'(RST_LOW_US);
        end_us = UW'(RST_END);
        samp_us = UW'(RST_LOW_US + PRES_SAMPLE_US);
        has_samp = 1'b1;
      end
      OP_WR: begin
        low_us = dbit ? UW'(W1_LOW_US) : UW'(W0_LOW_US);
        end_us = UW'(SLOT_US);
      end
      OP_RD: begin
        low_us = UW'(RD_LOW_US);
        end_us = UW'(SLOT_US);
        samp_us = UW'(RD_SAMPLE_US);
        has_samp = 1'b1;
      end
      default: begin
        low_us = '0;
        end_us = dbit ? UW'(SPU_LONG_US) : UW'(SPU_SHORT_US);
      end
    endcase
  end

  assign cmd_ready   = !busy;
  assign line_pull_n = !(busy && (us < low_us));
  assign spu_en      = busy && (op == OP_SPU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      op           <= OP_RST;
      dbit         <= 1'b0;
      pre          <= '0;
      us           <= '0;
      line_s       <= 2'b11;
      result_valid <= 1'b0;
      result_bit   <= 1'b0;
    end else begin
      line_s       <= {line_s[0], line_in};
      result_valid <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy       <= 1'b1;
          op         <= cmd_op;
          dbit       <= cmd_bit;
          pre        <= '0;
          us         <= '0;
          result_bit <= 1'b0;
        end
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          us <= us + 1'b1;
          if (has_samp && us == samp_us - UW'(1))
            result_bit <= (op == OP_RST) ? !line_s[1] : line_s[1];
          if (us == end_us - UW'(1)) begin
            busy         <= 1'b0;
            result_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module owm_slot_engine_chk #(
  parameter int CLK_PER_US = 200,
  parameter int RST_LOW_US = 480
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic line_pull_n,
  input logic spu_en,
  input logic result_valid
);
  int unsigned low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (!line_pull_n) low_run <= low_run + 1;
    else low_run <= 0;
  end

  // R8
  drive_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_pull_n |-> !cmd_ready);
  // R8
  low_run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RST_LOW_US * CLK_PER_US);
  // R9
  spu_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> line_pull_n);
  // R2
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R2
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> cmd_ready);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind owm_slot_engine owm_slot_engine_chk #(
  .CLK_PER_US(CLK_PER_US), .RST_LOW_US(RST_LOW_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .line_pull_n(line_pull_n), .spu_en(spu_en), .result_valid(result_valid)
);

// File: tb/sim_owm_slot_engine.sv
`timescale 1ns/1ps
module sim_owm_slot_engine;
  localparam int CPU = 4;
  localparam int SPU_S = 40;
  localparam int SPU_L = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_bit = 1'b0;
  logic cmd_ready, line_pull_n, spu_en, result_valid, result_bit;
  logic slave_n = 1'b1;
  wire  line_in = line_pull_n & slave_n;

  always #2.5 clk = ~clk;

  owm_slot_engine #(.CLK_PER_US(CPU), .SPU_SHORT_US(SPU_S), .SPU_LONG_US(SPU_L)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .line_in(line_in), .line_pull_n(line_pull_n),
    .spu_en(spu_en), .result_valid(result_valid), .result_bit(result_bit));

  // behavioural slave
  logic pres_en = 1'b1, rd_val = 1'b1, rx_bit = 1'b1, m_prev = 1'b1;
  int low_run = 0, since_rise = -1, since_fall = -1;
  always @(posedge clk) begin
    m_prev  <= line_pull_n;
    low_run <= line_pull_n ? 0 : low_run + 1;
    if (!m_prev && line_pull_n && low_run >= 480*CPU - 1 && pres_en) since_rise <= 0;
    else if (since_rise >= 0 && since_rise < 100000) since_rise <= since_rise + 1;
    if (m_prev && !line_pull_n) since_fall <= 0;
    else if (since_fall >= 0 && since_fall < 100000) since_fall <= since_fall + 1;
    if (since_fall == 30*CPU) rx_bit <= line_in;
    slave_n <= !((since_rise >= 30*CPU && since_rise < 150*CPU) ||
                 (since_fall >= 0 && since_fall < 30*CPU && !rd_val));
  end

  int checks = 0, errs = 0;
  int n_low, n_busy, n_spu;
  logic first_spu;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    n_low = 0; n_busy = 0; n_spu = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    first_spu = spu_en;
    forever begin
      if (result_valid) break;
      n_low  += !line_pull_n;
      n_busy += !cmd_ready;
      n_spu  += spu_en;
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 ready", cmd_ready, 1);
        chk("R1 line", line_pull_n, 1);
        chk("R1 spu", spu_en, 0);
        chk("R1 valid", result_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int p = 0; p < 2; p++) begin
          pres_en = p[0];
          run(2'b00, 1'b0);
          chk("R4 reset low cycles", n_low, 480*CPU);
          chk("R2 R4 reset busy cycles", n_busy, 960*CPU);
          chk("R5 presence", result_bit, p);
          chk("R2 ready at valid", cmd_ready, 1);
          @(negedge clk);
          chk("R2 pulse one cycle", result_valid, 0);
        end

        rd_val = 1'b1;
        for (int b = 0; b < 2; b++) begin
          run(2'b01, b[0]);
          chk("R6 write low cycles", n_low, (b ? 6 : 60)*CPU);
          chk("R6 write slot cycles", n_busy, 70*CPU);
          chk("R6 slave received", rx_bit, b);
          chk("R6 write result", result_bit, 0);
        end

        for (int b = 0; b < 2; b++) begin
          rd_val = b[0];
          run(2'b10, 1'b0);
          chk("R7 read low cycles", n_low, 2*CPU);
          chk("R7 read slot cycles", n_busy, 70*CPU);
          chk("R7 read value", result_bit, b);
          chk("R8 line released at end", line_pull_n, 1);
        end
        rd_val = 1'b1;

        for (int b = 0; b < 2; b++) begin
          run(2'b11, b[0]);
          chk("R9 spu cycles", n_spu, (b ? SPU_L : SPU_S)*CPU);
          chk("R9 spu immediate", first_spu, 1);
          chk("R9 spu no drive", n_low, 0);
          chk("R9 spu result", result_bit, 0);
          chk("R3 spu ends", spu_en, 0);
        end

        fork
          run(2'b01, 1'b0);
          begin
            repeat (20) @(negedge clk);
            cmd_op = 2'b11; cmd_bit = 1'b1; cmd_valid = 1'b1;
            repeat (10) @(negedge clk);
            cmd_valid = 1'b0;
          end
        join
        chk("R10 busy unchanged", n_busy, 70*CPU);
        chk("R10 no spu", n_spu, 0);
        n_busy = 0; n_spu = 0;
        repeat (20) begin
          @(negedge clk);
          n_busy += !cmd_ready;
          n_spu  += spu_en;
        end
        chk("R10 nothing started", n_busy, 0);
        chk("R10 no spu after", n_spu, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule